// File: doc/BRIEF.md
# I2C Slave Receive Byte Queue

This block buffers the bytes that an I2C slave receives before software reads them. A byte deserializer, which is not part of this block, presents each received byte on a one-cycle `byte_valid` strobe. The strobe carries a marker that says whether the byte is the matched slave address. The block holds up to two bytes in arrival order. Software takes them out through a registered read port with a pop strobe. A configuration input, `addr_capture`, decides whether the address byte takes up one of the two slots or is dropped before it reaches the queue.

When both slots are in use, the block keeps the bytes it already holds and discards every newer byte. A sticky `overflow` flag records that a loss has happened. Software is expected to drain or flush the queue fast enough that this does not occur. A flush empties the queue in a single cycle, and a separate strobe clears only the overflow flag.

Top module: `i2c_rx_queue`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `overflow` is 0 and `rd_data` is 0.
- R2: Bytes leave the queue in the order they arrived. A pop on a non-empty queue puts the oldest byte on `rd_data` in the cycle after the pop is sampled, and `rd_data` holds that value until the next successful pop.
- R3: When both slots are in use and a byte is offered without a same-cycle pop, the byte is discarded. The two stored bytes stay intact and are read out unchanged.
- R4: `overflow` becomes 1 in the cycle after a byte is discarded because the queue was full, and it stays 1 until it is cleared.
- R5: A pulse on `ovf_clear` drives `overflow` to 0 without changing the queue contents. If a discard happens in the same cycle as `ovf_clear`, the discard wins and `overflow` is 1.
- R6: With `addr_capture` = 1, a byte marked `byte_is_addr` = 1 is stored like a data byte. After the address byte and two data bytes arrive, the queue holds the address byte followed by data byte 0.
- R7: With `addr_capture` = 0, a byte marked `byte_is_addr` = 1 is ignored. It takes no slot and never sets `overflow`, so the queue holds data bytes 0 and 1.
- R8: A pop on an empty queue changes neither `rd_data` nor any flag.
- R9: When the queue is full and a byte arrives in the same cycle as a pop, the byte is accepted. The queue stays full, `overflow` stays 0, and the order is preserved.
- R10: `flush` empties the queue and clears `overflow` in one cycle. It takes priority over a same-cycle byte arrival and pop, and `rd_data` is left unchanged.
- R11: `empty` is 1 exactly when no byte is held, `full` is 1 exactly when two bytes are held, and the two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_capture | input | 1 | 1: the address byte is queued; 0: the address byte is dropped |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_is_addr | input | 1 | Marks the offered byte as the matched slave address |
| byte_data | input | DATA_W | Received byte |
| rd_pop | input | 1 | Read strobe that removes the oldest byte |
| flush | input | 1 | Empties the queue and clears overflow |
| ovf_clear | input | 1 | Clears the overflow flag only |
| rd_data | output | DATA_W | Last byte popped |
| empty | output | 1 | No byte held |
| full | output | 1 | Two bytes held |
| overflow | output | 1 | Sticky flag: a byte was discarded |

## Verification
The main sweep covers both settings of `addr_capture`, with an address byte followed by zero to three data bytes. This separates the case where the address takes a slot from the case where it is dropped, and it also separates fills below, at and above capacity. In each case the bench checks which two bytes survive, their order, and whether `overflow` is set. Directed sequences then cover the cases the sweep cannot tell apart: a pop on an empty queue, a push combined with a pop on a full queue, and a discard in the same cycle as `ovf_clear`. A last sequence applies a flush together with a push and a pop.

// File: rtl/i2c_rx_queue.sv
module i2c_rx_queue #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_capture,
  input  logic              byte_valid,
  input  logic              byte_is_addr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_pop,
  input  logic              flush,
  input  logic              ovf_clear,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  logic [DATA_W-1:0] head_q, tail_q;
  logic [1:0]        cnt_q;

  wire take    = byte_valid && (addr_capture || !byte_is_addr);
  wire pop_ok  = rd_pop && (cnt_q != 2'd0);
  wire push_ok = take && ((cnt_q != 2'd2) || pop_ok);
  wire drop    = take && (cnt_q == 2'd2) && !rd_pop;

  assign empty = (cnt_q == 2'd0);
  assign full  = (cnt_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= 2'd0;
      rd_data  <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      cnt_q    <= 2'd0;
      overflow <= 1'b0;
    end else begin
      if (pop_ok)
        rd_data <= head_q;
      case ({push_ok, pop_ok})
        2'b10: begin
          if (cnt_q == 2'd0) head_q <= byte_data;
          else               tail_q <= byte_data;
          cnt_q <= cnt_q + 2'd1;
        end
        2'b01: begin
          head_q <= tail_q;
          cnt_q  <= cnt_q - 2'd1;
        end
        2'b11: begin
          if (cnt_q == 2'd1) begin
            head_q <= byte_data;
          end else begin
            head_q <= tail_q;
            tail_q <= byte_data;
          end
        end
        default: ;
      endcase
      if (drop)
        overflow <= 1'b1;
      else if (ovf_clear)
        overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_rx_queue_chk.sv
module i2c_rx_queue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_capture,
  input logic              byte_valid,
  input logic              byte_is_addr,
  input logic              rd_pop,
  input logic              flush,
  input logic              ovf_clear,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty,
  input logic              full,
  input logic              overflow
);

  wire offered = byte_valid && (addr_capture || !byte_is_addr);

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && offered && !rd_pop && !flush |=> full);

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && offered && !rd_pop && !flush |=> overflow);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clear && !flush |=> overflow);

  // R5
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear && !flush && !(full && offered && !rd_pop) |=> !overflow);

  // R7
  addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_is_addr && !addr_capture && !rd_pop && !flush && !ovf_clear
    |=> $stable(empty) && $stable(full) && $stable(overflow));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_pop && !offered && !flush && !ovf_clear
    |=> empty && $stable(rd_data) && $stable(overflow));

  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_pop && offered && !flush |=> full);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow && $stable(rd_data));

endmodule

bind i2c_rx_queue i2c_rx_queue_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_i2c_rx_queue.sv
`timescale 1ns/1ps
module test_i2c_rx_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_capture = 1'b0;
  logic       byte_valid = 1'b0;
  logic       byte_is_addr = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       rd_pop = 1'b0;
  logic       flush = 1'b0;
  logic       ovf_clear = 1'b0;
  logic [7:0] rd_data;
  logic       empty, full, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_rx_queue #(.DATA_W(8)) i_i2c_rx_queue (
    .clk(clk), .rst_n(rst_n), .addr_capture(addr_capture),
    .byte_valid(byte_valid), .byte_is_addr(byte_is_addr), .byte_data(byte_data),
    .rd_pop(rd_pop), .flush(flush), .ovf_clear(ovf_clear),
    .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    byte_valid = 0; byte_is_addr = 0; rd_pop = 0; flush = 0; ovf_clear = 0;
  endtask

  task automatic push(input bit is_addr, input logic [7:0] d);
    byte_valid = 1; byte_is_addr = is_addr; byte_data = d;
    tick();
    idle();
  endtask

  task automatic pop();
    rd_pop = 1;
    tick();
    idle();
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
    idle();
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] expv [0:4];
    int len;
    logic [7:0] last;
    #20;
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    @(negedge clk);
    rst_n = 1;
    tick();

    // Sweep: capture setting x number of data bytes (R2 R3 R4 R6 R7 R11)
    for (int cap = 0; cap < 2; cap++) begin
      for (int n = 0; n < 4; n++) begin
        addr_capture = cap[0];
        do_flush();
        len = 0;
        push(1'b1, 8'hA0 + 8'(n));
        if (cap == 1) begin expv[len] = 8'hA0 + 8'(n); len++; end
        for (int i = 0; i < n; i++) begin
          push(1'b0, 8'(16 * (n + 1) + i));
          expv[len] = 8'(16 * (n + 1) + i);
          len++;
        end
        chk(cap ? "R6 overflow" : "R7 overflow", int'(overflow), int'(len > 2));
        chk("R11 full", int'(full), int'(len >= 2));
        chk("R11 empty", int'(empty), int'(len == 0));
        for (int k = 0; k < ((len > 2) ? 2 : len); k++) begin
          pop();
          chk(len > 2 ? "R3 kept byte" : (cap ? "R6 order" : "R2 order"),
              int'(rd_data), int'(expv[k]));
        end
        chk("R11 drained empty", int'(empty), 1);
        if (len > 0) begin
          last = rd_data;
          pop();
          chk("R8 rd_data held", int'(rd_data), int'(last));
          chk("R8 still empty", int'(empty), 1);
        end
      end
    end

    // R5: clear, then discard and clear in the same cycle
    addr_capture = 0;
    do_flush();
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
    chk("R4 overflow set", int'(overflow), 1);
    ovf_clear = 1; tick(); idle();
    chk("R5 cleared", int'(overflow), 0);
    chk("R5 still full", int'(full), 1);
    byte_valid = 1; byte_data = 8'h44; ovf_clear = 1; tick(); idle();
    chk("R5 set wins", int'(overflow), 1);
    pop(); chk("R3 first", int'(rd_data), 8'h11);
    pop(); chk("R3 second", int'(rd_data), 8'h22);

    // R9: push with pop on a full queue
    do_flush();
    push(0, 8'h51); push(0, 8'h52);
    byte_valid = 1; byte_data = 8'h53; rd_pop = 1; tick(); idle();
    chk("R9 rd_data", int'(rd_data), 8'h51);
    chk("R9 full", int'(full), 1);
    chk("R9 overflow", int'(overflow), 0);
    pop(); chk("R9 second", int'(rd_data), 8'h52);
    pop(); chk("R9 third", int'(rd_data), 8'h53);
    chk("R9 empty", int'(empty), 1);

    // R10: flush beats push and pop
    push(0, 8'h61); push(0, 8'h62); push(0, 8'h63);
    last = rd_data;
    flush = 1; byte_valid = 1; byte_data = 8'h64; rd_pop = 1; tick(); idle();
    chk("R10 empty", int'(empty), 1);
    chk("R10 overflow", int'(overflow), 0);
    chk("R10 rd_data", int'(rd_data), int'(last));
    push(0, 8'h65); pop();
    chk("R10 after flush", int'(rd_data), 8'h65);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule